// File: doc/BRIEF.md
# Coin Credit Controller with Registered Open Output

This block counts coin credit for a single-price dispenser. A nickel pulse adds five cents and a dime pulse adds ten cents. Credit is held as one of four levels: 0, 5, 10 or 15 cents. When the credit reaches 15 cents the `open_o` output goes high, and it stays high until reset returns the credit to zero. Credit never goes above 15 cents: any coin that would push it higher leaves it at 15.

The open output does not come from decoding the present credit. A dedicated flip-flop is loaded on each clock edge with "next credit is full". Its timing is therefore the same as a Moore output decoded from the state, but the output pin sees only a clock-to-Q delay. Coin inputs are single-cycle control pulses sampled on the rising clock edge. They carry no data, so they are plain pins with no valid/ready handshake and no back-pressure. The reset is synchronous and active high.

Top module: `coin_gate_ctrl`

## Requirements
- R1: A clock edge with `rst` high clears the credit to 0 cents and drives `open_o` low, regardless of the coin inputs in that cycle.
- R2: A nickel alone (`nickel_i`=1, `dime_i`=0) moves the credit 0→5, 5→10 and 10→15 cents at the sampling edge.
- R3: A dime alone (`dime_i`=1, `nickel_i`=0) moves the credit 0→10, 5→15 and 10→15 cents (saturating) at the sampling edge.
- R4: With both coin inputs low, the credit holds its value.
- R5: Once the credit is 15 cents, it stays there under any coin input until reset.
- R6: `open_o` is 1 exactly while the credit is 15 cents. It rises in the cycle that follows the edge at which the credit reaches 15 cents.
- R7: `open_o` changes only at a rising clock edge. A coin input that changes between edges has no effect on `open_o` until the next edge.
- R8: A nickel and a dime in the same cycle add 15 cents, which always results in full credit and `open_o`=1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle pulse: a five-cent coin was accepted |
| dime_i | input | 1 | One-cycle pulse: a ten-cent coin was accepted |
| open_o | output | 1 | High while the credit is 15 cents |

## Verification
`open_o` is the only port that shows the credit, so a wrong credit value can be seen only when it crosses the full boundary. A credit that is too high opens the gate early. That shows in the cycle after the offending coin. A credit that is too low shows as a missing rise after the coin that should have completed the price. A hold fault (drift with no coins) only becomes visible when a later coin gives the wrong result. For this reason the bench follows every credit path up to full, and it also compares the output with an independent Moore model on a long pseudo-random coin stream.

// File: rtl/coin_gate_pkg.sv
package coin_gate_pkg;

  // Credit is counted in steps of five cents.
  localparam int unsigned NICKEL_STEPS = 1;
  localparam int unsigned DIME_STEPS   = 2;

  typedef struct packed {
    logic nickel;
    logic dime;
  } coin_t;

endpackage

// File: rtl/coin_gate_next.sv
module coin_gate_next
  import coin_gate_pkg::*;
#(
  parameter int unsigned PRICE_STEPS = 3,
  parameter int unsigned CW          = $clog2(PRICE_STEPS + 1)
) (
  input  logic [CW-1:0] credit_i,
  input  coin_t         coins_i,
  output logic [CW-1:0] credit_nxt_o
);

  localparam int unsigned SW = CW + 2;
  localparam logic [SW-1:0] FULL_W = SW'(PRICE_STEPS);

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(credit_i);
    if (coins_i.nickel) sum = sum + SW'(NICKEL_STEPS);
    if (coins_i.dime)   sum = sum + SW'(DIME_STEPS);
    if (sum >= FULL_W) credit_nxt_o = CW'(PRICE_STEPS);
    else               credit_nxt_o = sum[CW-1:0];
  end

endmodule

// File: rtl/coin_gate_reg.sv
module coin_gate_reg #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/coin_gate_full_dec.sv
module coin_gate_full_dec #(
  parameter int unsigned PRICE_STEPS = 3,
  parameter int unsigned CW          = $clog2(PRICE_STEPS + 1)
) (
  input  logic [CW-1:0] credit_i,
  output logic          full_o
);

  assign full_o = (credit_i == CW'(PRICE_STEPS));

endmodule

// File: rtl/coin_gate_ctrl.sv
module coin_gate_ctrl
  import coin_gate_pkg::*;
#(
  parameter int unsigned PRICE_STEPS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);

  localparam int unsigned CW = $clog2(PRICE_STEPS + 1);

  coin_t         coins;
  logic [CW-1:0] credit_q;
  logic [CW-1:0] credit_nxt;
  logic          full_nxt;

  assign coins.nickel = nickel_i;
  assign coins.dime   = dime_i;

  coin_gate_next #(.PRICE_STEPS(PRICE_STEPS), .CW(CW)) u_next (
    .credit_i     (credit_q),
    .coins_i      (coins),
    .credit_nxt_o (credit_nxt)
  );

  coin_gate_reg #(.W(CW)) u_credit (
    .clk (clk),
    .rst (rst),
    .d_i (credit_nxt),
    .q_o (credit_q)
  );

  // The full decode is taken from the next credit, so the open flop shows
  // the Moore value with no decode after the clock edge.
  coin_gate_full_dec #(.PRICE_STEPS(PRICE_STEPS), .CW(CW)) u_dec (
    .credit_i (credit_nxt),
    .full_o   (full_nxt)
  );

  coin_gate_reg #(.W(1)) u_open (
    .clk (clk),
    .rst (rst),
    .d_i (full_nxt),
    .q_o (open_o)
  );

endmodule

module coin_gate_chk #(
  parameter int unsigned PRICE_STEPS = 3,
  parameter int unsigned CW          = $clog2(PRICE_STEPS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          nickel_i,
  input logic          dime_i,
  input logic          open_o,
  input logic [CW-1:0] credit
);

  localparam logic [CW-1:0] FULL = CW'(PRICE_STEPS);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (credit == '0 && !open_o));

  a_r2_nickel_step: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && !dime_i && credit < FULL) |=> credit == $past(credit) + 1'b1);

  a_r3_dime_reaches_full: assert property (@(posedge clk) disable iff (rst)
    (dime_i && !nickel_i && credit >= FULL - 1'b1) |=> credit == FULL);

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(credit));

  a_r5_full_sticky: assert property (@(posedge clk) disable iff (rst)
    (credit == FULL) |=> credit == FULL);

  a_r6_open_matches_state: assert property (@(posedge clk) disable iff (rst)
    open_o == (credit == FULL));

  a_r8_both_coins_fill: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && dime_i) |=> open_o);

endmodule

bind coin_gate_ctrl coin_gate_chk #(.PRICE_STEPS(PRICE_STEPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .nickel_i (nickel_i),
  .dime_i   (dime_i),
  .open_o   (open_o),
  .credit   (credit_q)
);

// File: tb/coin_gate_ctrl_test.sv
module coin_gate_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 24;

  // Vector fields: {rst, nickel, dime, expected open after the edge}
  localparam logic [3:0] VEC [NV] = '{
    4'b1_0_0_0, // R1 reset
    4'b0_1_0_0, // R2 0->5
    4'b0_0_0_0, // R4 hold 5
    4'b0_1_0_0, // R2 5->10
    4'b0_0_1_1, // R3 10->15
    4'b0_0_0_1, // R5 hold full
    4'b0_1_0_1, // R5 nickel at full
    4'b0_0_1_1, // R5 dime at full
    4'b1_0_0_0, // R1 reset from full
    4'b0_0_1_0, // R3 0->10
    4'b0_0_0_0, // R4 hold 10
    4'b0_1_0_1, // R2 10->15
    4'b1_0_0_0, // R1
    4'b0_0_1_0, // R3 0->10
    4'b0_0_1_1, // R3 10->15 saturating
    4'b1_0_0_0, // R1
    4'b0_1_0_0, // R2 0->5
    4'b0_0_1_1, // R3 5->15
    4'b1_0_0_0, // R1
    4'b0_1_0_0, // R2 0->5
    4'b0_1_0_0, // R2 5->10
    4'b0_1_0_1, // R2 10->15
    4'b1_1_0_0, // R1 reset wins over coin
    4'b0_0_0_0  // R4 hold 0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic open_w;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  coin_gate_ctrl uut (
    .clk      (clk),
    .rst      (rst),
    .nickel_i (nickel),
    .dime_i   (dime),
    .open_o   (open_w)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: open actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic step(input logic r, input logic n, input logic d);
    @(negedge clk);
    rst = r; nickel = n; dime = d;
    @(posedge clk);
    #1;
  endtask

  int model;

  initial begin
    logic [15:0] lfsr;
    // R1: open is low while in reset
    step(1'b1, 1'b0, 1'b0);
    check("R1 reset state", open_w, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][3], VEC[i][2], VEC[i][1]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), open_w, VEC[i][0]);
    end

    // R8: both coins together from 0 fill the credit
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    check("R8 both coins from 0", open_w, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    check("R5 full after both coins", open_w, 1'b1);

    // R7: coin raised mid-cycle does not change open before the edge
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b0; nickel = 1'b0; dime = 1'b1;
    #1;
    check("R7 no change before edge", open_w, 1'b0);
    @(posedge clk);
    #1;
    check("R7 rise after edge", open_w, 1'b1);

    // R1: reset during full with both coins present
    step(1'b1, 1'b1, 1'b1);
    check("R1 reset over both coins", open_w, 1'b0);

    // R6: pseudo-random stream against a Moore model, no simultaneous coins
    model = 0;
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      logic r, n, d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = (lfsr[7:4] == 4'd0);
      n = lfsr[0] & lfsr[2];
      d = lfsr[1] & lfsr[3] & ~n;
      step(r, n, d);
      if (r) model = 0;
      else begin
        model = model + (n ? 1 : 0) + (d ? 2 : 0);
        if (model > 3) model = 3;
      end
      check("R6 Moore model", open_w, (model == 3));
    end

    step(1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule